// File: doc/BRIEF.md
# Serial NOR Flash Erase Sequencer

This block runs one erase operation on a serial NOR flash through a simple command engine. A caller pulses `start` with an erase size code and a byte address. The sequencer first validates the request. A request that fails validation finishes at once with an error code and never touches the command engine. A request that passes issues three kinds of command in turn. The first is a write-enable. The second is the erase opcode that matches the requested size. The third is a flag-status read, repeated until the flash reports that it is ready.

The command engine is a level handshake. The sequencer holds `cmd_req` with a stable opcode, address count, address and read length until the engine pulses `cmd_ack`. On a read command, the engine returns its byte on `cmd_rdata` in the same cycle as `cmd_ack`. A command that is still requested in the cycle after an acknowledge is a new command.

The block does not model how long the erase takes. The poll loop absorbs that time.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset, `busy`, `done` and `cmd_req` are low and `err` is 0.
- R2: An accepted request issues exactly this order of commands. First comes write-enable: opcode 0x06, no address bytes, no read. Then comes one erase command. Then comes one or more flag-status reads. Each command stays requested, with unchanged fields, until it is acknowledged.
- R3: Size code 0 (4 KB) sends opcode 0x20. Size code 1 (32 KB) sends 0x52. Size code 2 (64 KB) sends 0xD8. Each of these sends ceil(ADDR_W/8) address bytes carrying the latched address, and no read byte.
- R4: Size code 3 (whole chip) sends opcode 0xC7 with zero address bytes, and is accepted only at address 0.
- R5: A misaligned request ends with `err` = 1. For code 0 this means any of address bits [11:0] set. For code 1 it means any of bits [14:0] set. For code 2 it means any of bits [15:0] set. For code 3 it means any nonzero address.
- R6: An address greater than or equal to DEV_BYTES ends with `err` = 2. This check takes priority over misalignment.
- R7: Size codes 4 to 7 end with `err` = 3. This check takes priority over all other checks.
- R8: A rejected request drives `cmd_req` in no cycle. Its `done` pulse comes in the cycle after `start` is sampled.
- R9: The flag-status read uses opcode 0x70, no address bytes and one read byte. It repeats while bit 7 of the returned byte is 0. `done` rises in the cycle after an acknowledge whose byte has bit 7 set. No other bit of that byte matters.
- R10: `done` is a one-cycle pulse with `busy` low. On success `err` is 0. While a request is in progress, `start`, the size code and the address are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, sampled only when idle |
| etype | input | 3 | Erase size code: 0=4 KB, 1=32 KB, 2=64 KB, 3=whole chip, 4..7 invalid |
| addr | input | ADDR_W | Byte address of the erase region |
| busy | output | 1 | A command sequence is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 2 | Result code, valid with `done`: 0 ok, 1 misaligned, 2 out of range, 3 invalid type |
| cmd_req | output | 1 | Command request to the engine |
| cmd_opcode | output | 8 | Command opcode |
| cmd_naddr | output | 3 | Number of address bytes to send |
| cmd_addr | output | ADDR_W | Address to send |
| cmd_rdlen | output | 1 | One byte is read back after the command |
| cmd_ack | input | 1 | Engine has finished the current command |
| cmd_rdata | input | 8 | Byte read back, valid with `cmd_ack` |

## Verification
The bench sweeps every size code over a grid of addresses. The grid includes addresses just inside and beyond the device limit, and offsets that break only the finer alignments. This catches error codes given in the wrong priority order. It also catches an alignment mask one bit short, and a whole-chip erase that sends address bytes. Polls return bytes with every bit set except bit 7 before the ready byte. A design that tested the wrong bit, or stopped polling early, would show a different command count. Engine latency varies, so a design that dropped its request before the acknowledge would break the recorded sequence. The inputs change right after `start` and a second `start` arrives mid-sequence. A design that read its inputs live, or restarted, would send the wrong address or return a false error.

// File: rtl/erase_pkg.sv
package erase_pkg;

   // command opcodes understood by the flash
   localparam logic [7:0] OPC_WR_EN   = 8'h06;
   localparam logic [7:0] OPC_FLAG_RD = 8'h70;
   localparam logic [7:0] OPC_ERS_4K  = 8'h20;
   localparam logic [7:0] OPC_ERS_32K = 8'h52;
   localparam logic [7:0] OPC_ERS_64K = 8'hD8;
   localparam logic [7:0] OPC_ERS_ALL = 8'hC7;

   // erase size codes
   localparam logic [2:0] SZ_4K  = 3'd0;
   localparam logic [2:0] SZ_32K = 3'd1;
   localparam logic [2:0] SZ_64K = 3'd2;
   localparam logic [2:0] SZ_ALL = 3'd3;

   // alignment shifts per granularity
   localparam int SH_4K  = 12;
   localparam int SH_32K = 15;
   localparam int SH_64K = 16;

   // ready bit inside the flag status byte
   localparam int RDY_BIT = 7;

   typedef enum logic [1:0] {
      RES_OK    = 2'd0,
      RES_ALIGN = 2'd1,
      RES_RANGE = 2'd2,
      RES_TYPE  = 2'd3
   } res_t;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_WREN  = 3'd1,
      ST_ERASE = 3'd2,
      ST_POLL  = 3'd3,
      ST_FIN   = 3'd4
   } seq_st_t;

endpackage

// File: rtl/erase_req_check.sv
module erase_req_check
   import erase_pkg::*;
#(
   parameter int              ADDR_W    = 24,
   parameter longint unsigned DEV_BYTES = 64'd16777216
)(
   input  logic [2:0]        etype,
   input  logic [ADDR_W-1:0] addr,
   output res_t              result
);

   localparam longint unsigned SPAN = 64'd1 << ADDR_W;

   logic over;
   logic misal;

   // range test: omitted when the device fills the whole address space
   generate
      if (DEV_BYTES >= SPAN) begin : g_full_span
         assign over = 1'b0;
      end else begin : g_part_span
         localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(DEV_BYTES);
         assign over = (addr >= LIMIT);
      end
   endgenerate

   always_comb begin
      unique case (etype)
         SZ_4K:   misal = |addr[SH_4K-1:0];
         SZ_32K:  misal = |addr[SH_32K-1:0];
         SZ_64K:  misal = |addr[SH_64K-1:0];
         SZ_ALL:  misal = |addr;
         default: misal = 1'b0;
      endcase
   end

   // priority: type, then range, then alignment
   always_comb begin
      if (etype > SZ_ALL)  result = RES_TYPE;
      else if (over)       result = RES_RANGE;
      else if (misal)      result = RES_ALIGN;
      else                 result = RES_OK;
   end

endmodule

// File: rtl/erase_cmd_sel.sv
module erase_cmd_sel
   import erase_pkg::*;
#(
   parameter int ADDR_W  = 24,
   parameter int N_ABYTE = 3
)(
   input  seq_st_t           st,
   input  logic [2:0]        etype_q,
   input  logic [ADDR_W-1:0] addr_q,
   output logic [7:0]        opcode,
   output logic [2:0]        naddr,
   output logic [ADDR_W-1:0] caddr,
   output logic              rdlen
);

   localparam logic [2:0] NAB = 3'(N_ABYTE);

   logic [7:0] ers_op;

   always_comb begin
      unique case (etype_q[1:0])
         2'd0:    ers_op = OPC_ERS_4K;
         2'd1:    ers_op = OPC_ERS_32K;
         2'd2:    ers_op = OPC_ERS_64K;
         default: ers_op = OPC_ERS_ALL;
      endcase
   end

   always_comb begin
      opcode = 8'h00;
      naddr  = 3'd0;
      caddr  = '0;
      rdlen  = 1'b0;
      unique case (st)
         ST_WREN:  opcode = OPC_WR_EN;
         ST_ERASE: begin
            opcode = ers_op;
            if (etype_q != SZ_ALL) begin
               naddr = NAB;
               caddr = addr_q;
            end
         end
         ST_POLL: begin
            opcode = OPC_FLAG_RD;
            rdlen  = 1'b1;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/erase_seq_fsm.sv
module erase_seq_fsm
   import erase_pkg::*;
#(
   parameter int ADDR_W = 24
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [2:0]        etype,
   input  logic [ADDR_W-1:0] addr,
   input  res_t              chk_res,
   input  logic              cmd_ack,
   input  logic [7:0]        cmd_rdata,
   output seq_st_t           st,
   output logic [2:0]        etype_q,
   output logic [ADDR_W-1:0] addr_q,
   output res_t              res_q,
   output logic              busy,
   output logic              done,
   output logic              cmd_req
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         etype_q <= '0;
         addr_q  <= '0;
         res_q   <= RES_OK;
      end else begin
         unique case (st)
            ST_IDLE: if (start) begin
               etype_q <= etype;
               addr_q  <= addr;
               res_q   <= chk_res;
               st      <= (chk_res == RES_OK) ? ST_WREN : ST_FIN;
            end
            ST_WREN:  if (cmd_ack) st <= ST_ERASE;
            ST_ERASE: if (cmd_ack) st <= ST_POLL;
            ST_POLL:  if (cmd_ack && cmd_rdata[RDY_BIT]) st <= ST_FIN;
            ST_FIN:   st <= ST_IDLE;
            default:  st <= ST_IDLE;
         endcase
      end
   end

   assign busy    = (st == ST_WREN) || (st == ST_ERASE) || (st == ST_POLL);
   assign cmd_req = busy;
   assign done    = (st == ST_FIN);

   AST_REQ_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_req |-> (res_q == RES_OK)); // R8
   AST_REJECT_FAST: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && start && chk_res != RES_OK) |=> (done && !cmd_req)); // R8
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy)); // R10
   AST_POLL_AGAIN: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_POLL && cmd_ack && !cmd_rdata[RDY_BIT]) |=> (st == ST_POLL)); // R9
   AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_req && !cmd_ack) |=> (cmd_req && $stable(st))); // R2
   AST_LATCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(addr_q) && $stable(etype_q)); // R10

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
   import erase_pkg::*;
#(
   parameter int              ADDR_W    = 24,
   parameter longint unsigned DEV_BYTES = 64'd12582912
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [2:0]        etype,
   input  logic [ADDR_W-1:0] addr,
   output logic              busy,
   output logic              done,
   output logic [1:0]        err,
   output logic              cmd_req,
   output logic [7:0]        cmd_opcode,
   output logic [2:0]        cmd_naddr,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic              cmd_rdlen,
   input  logic              cmd_ack,
   input  logic [7:0]        cmd_rdata
);

   localparam int N_ABYTE = (ADDR_W + 7) / 8;

   generate
      if (ADDR_W < SH_64K + 1 || ADDR_W > 32) begin : g_bad_addr_w
         $error("flash_erase_seq: ADDR_W must lie in 17..32");
      end
      if (DEV_BYTES == 0) begin : g_bad_dev
         $error("flash_erase_seq: DEV_BYTES must be nonzero");
      end
   endgenerate

   res_t              chk_res;
   res_t              res_q;
   seq_st_t           st;
   logic [2:0]        etype_q;
   logic [ADDR_W-1:0] addr_q;

   erase_req_check #(.ADDR_W(ADDR_W), .DEV_BYTES(DEV_BYTES)) u_check (
      .etype  (etype),
      .addr   (addr),
      .result (chk_res)
   );

   erase_seq_fsm #(.ADDR_W(ADDR_W)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .etype     (etype),
      .addr      (addr),
      .chk_res   (chk_res),
      .cmd_ack   (cmd_ack),
      .cmd_rdata (cmd_rdata),
      .st        (st),
      .etype_q   (etype_q),
      .addr_q    (addr_q),
      .res_q     (res_q),
      .busy      (busy),
      .done      (done),
      .cmd_req   (cmd_req)
   );

   erase_cmd_sel #(.ADDR_W(ADDR_W), .N_ABYTE(N_ABYTE)) u_sel (
      .st      (st),
      .etype_q (etype_q),
      .addr_q  (addr_q),
      .opcode  (cmd_opcode),
      .naddr   (cmd_naddr),
      .caddr   (cmd_addr),
      .rdlen   (cmd_rdlen)
   );

   assign err = res_q;

   AST_CHIP_NOADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_req && cmd_opcode == OPC_ERS_ALL) |-> (cmd_naddr == 3'd0)); // R4
   AST_ERASE_NOREAD: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_req && cmd_opcode != OPC_FLAG_RD) |-> !cmd_rdlen); // R3
   AST_POLL_ONEBYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_req && cmd_opcode == OPC_FLAG_RD) |-> (cmd_rdlen && cmd_naddr == 3'd0)); // R9
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_req |-> (cmd_opcode == 8'h00)); // R8

endmodule

// File: tb/test_flash_erase_seq.sv
module test_flash_erase_seq;

   localparam int              AW  = 18;
   localparam longint unsigned DEV = 64'd196608;
   localparam int              NAB = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [2:0]    etype = '0;
   logic [AW-1:0] addr = '0;
   logic          busy, done, cmd_req, cmd_rdlen;
   logic [1:0]    err;
   logic [7:0]    cmd_opcode;
   logic [2:0]    cmd_naddr;
   logic [AW-1:0] cmd_addr;
   logic          cmd_ack = 1'b0;
   logic [7:0]    cmd_rdata = '0;

   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   flash_erase_seq #(.ADDR_W(AW), .DEV_BYTES(DEV)) i_flash_erase_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .etype(etype), .addr(addr),
      .busy(busy), .done(done), .err(err), .cmd_req(cmd_req),
      .cmd_opcode(cmd_opcode), .cmd_naddr(cmd_naddr), .cmd_addr(cmd_addr),
      .cmd_rdlen(cmd_rdlen), .cmd_ack(cmd_ack), .cmd_rdata(cmd_rdata)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int exp_err(input int t, input int a);
      if (t > 3) return 3;
      if (a >= int'(DEV)) return 2;
      case (t)
         0: return (a % 4096) != 0 ? 1 : 0;
         1: return (a % 32768) != 0 ? 1 : 0;
         2: return (a % 65536) != 0 ? 1 : 0;
         default: return (a != 0) ? 1 : 0;
      endcase
   endfunction

   function automatic logic [7:0] exp_op(input int t);
      case (t)
         0: return 8'h20;
         1: return 8'h52;
         2: return 8'hD8;
         default: return 8'hC7;
      endcase
   endfunction

   task automatic run_req(input int t, input int a, input int lat, input int polls, input bit poke);
      int e = exp_err(t, a);
      int ncmd = 0;
      int waitc = 0;
      int npoll = 0;
      int cyc = 0;
      bit fresh = 1'b1;
      bit seq_ok = 1'b1;
      logic [7:0] op_seen;
      @(negedge clk);
      start = 1'b1; etype = 3'(t); addr = AW'(a);
      @(negedge clk);
      start = 1'b0; etype = 3'd7; addr = '1;   // inputs change; latched values must be used
      while (!done && cyc < 400) begin
         if (cmd_req) begin
            op_seen = cmd_opcode;
            if (fresh) begin
               fresh = 1'b0; waitc = 0;
               if (ncmd == 0) begin
                  if (cmd_opcode != 8'h06 || cmd_naddr != 0 || cmd_rdlen) seq_ok = 1'b0;   // R2
               end else if (ncmd == 1) begin
                  if (cmd_opcode != exp_op(t) || cmd_rdlen) seq_ok = 1'b0;                 // R3
                  if (t == 3 && cmd_naddr != 0) seq_ok = 1'b0;                             // R4
                  if (t != 3 && (cmd_naddr != NAB || cmd_addr != AW'(a))) seq_ok = 1'b0;   // R3
               end else begin
                  if (cmd_opcode != 8'h70 || cmd_naddr != 0 || !cmd_rdlen) seq_ok = 1'b0;  // R9
               end
            end
            if (waitc == lat) begin
               cmd_ack = 1'b1;
               if (op_seen == 8'h70) begin
                  cmd_rdata = (npoll < polls) ? 8'h7F : 8'h80;
                  npoll++;
               end else cmd_rdata = 8'h00;
               ncmd++; fresh = 1'b1;
            end else waitc++;
         end
         if (poke && cyc == 2) begin
            start = 1'b1; etype = 3'd5; addr = AW'(1);   // R10 ignored while busy
         end
         @(negedge clk);
         cmd_ack = 1'b0; start = 1'b0;
         cyc++;
      end
      chk(done, "R10 done reached", done, 1);
      chk(err == 2'(e), (e == 3) ? "R7 err" : (e == 2) ? "R6 err" : (e == 1) ? "R5 err" : "R10 err", err, e);
      if (e == 0) begin
         chk(seq_ok, "R2 R3 R4 R9 command fields", seq_ok, 1);
         chk(ncmd == polls + 3, "R9 command count", ncmd, polls + 3);
      end else begin
         chk(ncmd == 0 && cyc == 0, "R8 rejected without traffic", ncmd * 1000 + cyc, 0);
      end
      chk(!busy, "R10 busy low with done", busy, 0);
      @(negedge clk);
      chk(!done && !busy, "R10 done one cycle", {done, busy}, 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog actual=expired expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(!busy && !done && !cmd_req && err == 0, "R1 reset state", {busy, done, cmd_req, err}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !cmd_req, "R1 after release", {busy, done, cmd_req}, 0);
      // sweep: all codes over a 1 KB grid with sprinkled odd offsets
      for (int g = 0; g < 256; g++) begin
         for (int t = 0; t < 8; t++) begin
            int a = g * 1024 + (((g % 7) == 3) ? 5 : 0);
            run_req(t, a, (g + t) % 3, (g + t) % 4, 1'b0);
         end
      end
      // boundary addresses around the device limit and alignment edges
      run_req(2, int'(DEV) - 65536, 1, 2, 1'b0);
      run_req(0, int'(DEV) - 4096, 0, 0, 1'b0);
      run_req(0, int'(DEV), 0, 0, 1'b0);
      run_req(3, int'(DEV) + 1, 0, 0, 1'b0);
      run_req(1, 32768 + 16384, 0, 0, 1'b0);
      run_req(2, 32768, 0, 0, 1'b0);
      // start pulses mid-sequence must be ignored
      run_req(0, 8192, 2, 3, 1'b1);
      run_req(3, 0, 1, 5, 1'b1);
      run_req(2, 65536, 0, 1, 1'b1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule